// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Register Front-End

This block is the bus-facing register layer of a floppy controller. It comes out of reset in a legacy soft-switch personality. A bus access in that personality flips one of eight single-bit switches. The switch is chosen by the slot address alone, and the data lines play no part. A write is captured only when both shift-control switches are on. If the motor switch is on, the byte goes into a data holding register. If it is off, the byte goes into a legacy mode register.

The block watches the bytes that land in the legacy mode register for an unlock pattern. When the pattern completes, the block moves into an extended personality and stays there until reset. The extended personality has three registers:
- a phase register that can be written and read back;
- a control register written through separate clear and set slots;
- a handshake register that reports a sense bit for one phase code.

The bus window is 0x2000 bytes. The slot number is taken from the upper address bits, which gives sixteen slots.

Top module: `flopfe_top`

## Requirements
- R1: The slot number is the bus address shifted right by 9 (address bits 12:9). The lower nine address bits have no effect on any result.
- R2: In legacy mode, every access (read or write) sets switch number slot[3:1] to the value of slot[0]. The switches are numbered 0–3 phase, 4 motor, 5 drive select, 6 shift-control low (Q6) and 7 shift-control high (Q7). A legacy-mode read always returns 0x00.
- R3: A legacy write stores its byte only when switches 6 and 7 are both 1. These values are taken after the same access has updated its own switch. With motor switch 4 at 1, the byte goes to the data register and does not count toward unlocking. With switch 4 at 0, the byte goes to the legacy mode register.
- R4: Bytes stored to the legacy mode register step an unlock position through the pattern 0x57, 0x17, 0x57, 0x57. A byte that does not match the expected value leaves the position unchanged.
- R5: The write that completes the fourth match raises `ext_mode` on the following clock edge and returns the position to the start.
- R6: In extended mode, a write to slot 4 loads the phase register. A read of slot 12 returns the phase register.
- R7: In extended mode, a write to slot 6 clears each control bit that is 1 in the byte. A write to slot 7 sets each control bit that is 1 in the byte. `ext_ctrl` shows the control register.
- R8: In extended mode, a read of slot 15 returns 0x08 when the phase register holds 0x77. In every other case it returns 0x00.
- R9: In extended mode, writes to slots 0, 1, 2, 3 and 5 change nothing. Reads of every slot other than 12 and 15 return 0x00.
- R10: Reset selects legacy mode. It clears the unlock position, all eight switches, both legacy registers, the phase register and the control register.
- R11: Once in extended mode, the block stays there until reset, whatever is written.
- R12: When `bus_wr` and `bus_rd` are both high, the access is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte address within the 0x2000 window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Read data for the addressed slot, combinational |
| ext_mode | output | 1 | High once the extended personality is active |
| ext_ctrl | output | 8 | Extended control register (clear/set slots) |

## Verification
Read data is combinational. It is due in the same cycle as the read strobe and reflects state from before that cycle's edge. The bench drives each access on the falling edge and compares `bus_rdata` one time unit later, before the rising edge.

Switch, unlock, phase and control updates take effect on the rising edge of the access. So `ext_mode` and `ext_ctrl` are compared one time unit after that edge. Any effect on a later read is checked by the next access.

The reference model advances only at the rising edge. Every comparison therefore pairs the model state from before the access with `bus_rdata`, and the model state from after the access with the registered outputs.

// File: rtl/flopfe_pkg.sv
package flopfe_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_SW    = 8;
    localparam int SEQ_LEN   = 4;
    localparam int POS_W     = $clog2(SEQ_LEN);

    // Switch numbering inside the legacy personality
    localparam int SW_MOTOR  = 4;
    localparam int SW_DRIVE  = 5;
    localparam int SW_SHL    = 6;
    localparam int SW_SHH    = 7;

    // Extended slot numbers
    localparam int SLOT_PHASE_WR = 4;
    localparam int SLOT_CTRL_CLR = 6;
    localparam int SLOT_CTRL_SET = 7;
    localparam int SLOT_PHASE_RD = 12;
    localparam int SLOT_HSHAKE   = 15;

    // Unlock pattern, element 0 expected first
    localparam logic [SEQ_LEN-1:0][DATA_W-1:0] UNLOCK_PAT =
        {8'h57, 8'h57, 8'h17, 8'h57};

    localparam logic [DATA_W-1:0] SENSE_PHASE = 8'h77;
    localparam logic [DATA_W-1:0] SENSE_FLAG  = 8'h08;

    typedef struct packed {
        logic [NUM_SW-1:0] sw;
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] mreg;
    } leg_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] phase;
        logic [DATA_W-1:0] ctrl;
    } ext_state_t;

endpackage

// File: rtl/flopfe_slot_dec.sv
module flopfe_slot_dec #(
    parameter int ADDR_W     = 13,
    parameter int SLOT_SHIFT = 9,
    parameter int SLOT_W     = ADDR_W - SLOT_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [SLOT_W-1:0] slot,
    output logic              acc,
    output logic              is_wr
);
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted = addr >> SLOT_SHIFT;
        slot    = shifted[SLOT_W-1:0];
        acc     = wr | rd;
        is_wr   = wr;          // R12: write wins over read
    end
endmodule

// File: rtl/flopfe_legacy.sv
module flopfe_legacy
    import flopfe_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              acc,
    input  logic              wr,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlock
);
    leg_state_t st_d, st_q;
    logic       store_ok;
    logic       pat_hit;

    always_comb begin
        st_d     = st_q;
        unlock   = 1'b0;
        store_ok = 1'b0;
        pat_hit  = (wdata == UNLOCK_PAT[st_q.pos]);
        if (en && acc) begin
            st_d.sw[slot[SLOT_W-1:1]] = slot[0];
            store_ok = wr && st_d.sw[SW_SHL] && st_d.sw[SW_SHH];
            if (store_ok) begin
                if (st_d.sw[SW_MOTOR]) begin
                    st_d.dat = wdata;
                end else begin
                    st_d.mreg = wdata;
                    if (pat_hit) begin
                        if (st_q.pos == POS_W'(SEQ_LEN - 1)) begin
                            st_d.pos = '0;
                            unlock   = 1'b1;
                        end else begin
                            st_d.pos = st_q.pos + 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_switch_follows_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc) |=> (st_q.sw[$past(slot[SLOT_W-1:1])] == $past(slot[0])));

    a_r4_mismatch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata != UNLOCK_PAT[st_q.pos]) |=> $stable(st_q.pos));

    a_r5_unlock_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> (st_q.pos == '0));

    a_r3_data_path_no_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc && wr && st_d.sw[SW_MOTOR]) |-> !unlock);
endmodule

// File: rtl/flopfe_ext.sv
module flopfe_ext
    import flopfe_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] phase,
    output logic [DATA_W-1:0] ctrl
);
    ext_state_t st_d, st_q;
    logic       wr_phase, wr_clr, wr_set;

    always_comb begin
        st_d     = st_q;
        wr_phase = en && wr && (slot == SLOT_W'(SLOT_PHASE_WR));
        wr_clr   = en && wr && (slot == SLOT_W'(SLOT_CTRL_CLR));
        wr_set   = en && wr && (slot == SLOT_W'(SLOT_CTRL_SET));
        if (wr_phase) st_d.phase = wdata;
        if (wr_clr)   st_d.ctrl  = st_q.ctrl & ~wdata;
        if (wr_set)   st_d.ctrl  = st_q.ctrl | wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign ctrl  = st_q.ctrl;

    a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && wr && slot == SLOT_W'(SLOT_PHASE_WR)) |=> $stable(phase));

    a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && slot == SLOT_W'(SLOT_CTRL_SET)) |=> ((ctrl & $past(wdata)) == $past(wdata)));

    a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && slot == SLOT_W'(SLOT_CTRL_CLR)) |=> ((ctrl & $past(wdata)) == '0));

    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && wr && (slot == SLOT_W'(SLOT_CTRL_CLR) || slot == SLOT_W'(SLOT_CTRL_SET)))
        |=> $stable(ctrl));
endmodule

// File: rtl/flopfe_top.sv
module flopfe_top
    import flopfe_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int SLOT_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              ext_mode,
    output logic [7:0]        ext_ctrl
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    typedef struct packed {
        logic ext;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [SLOT_W-1:0] slot;
    logic              acc, is_wr, unlock;
    logic [DATA_W-1:0] phase, ctrl;

    flopfe_slot_dec #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT), .SLOT_W(SLOT_W)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .slot(slot), .acc(acc), .is_wr(is_wr)
    );

    flopfe_legacy #(.SLOT_W(SLOT_W)) u_leg (
        .clk(clk), .rst_n(rst_n), .en(!st_q.ext), .acc(acc), .wr(is_wr),
        .slot(slot), .wdata(bus_wdata), .unlock(unlock)
    );

    flopfe_ext #(.SLOT_W(SLOT_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .en(st_q.ext), .wr(is_wr),
        .slot(slot), .wdata(bus_wdata), .phase(phase), .ctrl(ctrl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ext = st_q.ext | unlock;   // R11: no path back to legacy
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (st_q.ext && bus_rd && !bus_wr) begin
            if (slot == SLOT_W'(SLOT_PHASE_RD))
                bus_rdata = phase;
            else if (slot == SLOT_W'(SLOT_HSHAKE) && phase == SENSE_PHASE)
                bus_rdata = SENSE_FLAG;
        end
    end

    assign ext_mode = st_q.ext;
    assign ext_ctrl = ctrl;

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> ext_mode);

    a_r2_legacy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (bus_rdata == '0));

    a_r8_no_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && slot == SLOT_W'(SLOT_HSHAKE) && phase != SENSE_PHASE) |-> (bus_rdata == '0));

    a_r10_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (!ext_mode && ext_ctrl == '0));
endmodule

// File: tb/sim_flopfe_top.sv
module sim_flopfe_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ext_mode;
    logic [7:0]  ext_ctrl;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    flopfe_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_mode(ext_mode), .ext_ctrl(ext_ctrl)
    );

    // Reference model state
    bit [7:0] m_sw;
    int       m_pos;
    bit       m_ext;
    bit [7:0] m_phase, m_ctrl, m_dat, m_mreg;
    bit [7:0] pat [4] = '{8'h57, 8'h17, 8'h57, 8'h57};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] model_read(input int slot, input bit w, input bit r);
        if (!m_ext || w || !r) return 8'h00;
        if (slot == 12) return m_phase;
        if (slot == 15) return (m_phase == 8'h77) ? 8'h08 : 8'h00;
        return 8'h00;
    endfunction

    task automatic model_step(input int slot, input bit w, input bit r, input bit [7:0] d);
        if (!(w || r)) return;
        if (!m_ext) begin
            m_sw[slot >> 1] = slot[0];
            if (w && m_sw[6] && m_sw[7]) begin
                if (m_sw[4]) m_dat = d;
                else begin
                    m_mreg = d;
                    if (d == pat[m_pos]) begin
                        if (m_pos == 3) begin m_pos = 0; m_ext = 1; end
                        else m_pos++;
                    end
                end
            end
        end else if (w) begin
            if (slot == 4) m_phase = d;
            if (slot == 6) m_ctrl = m_ctrl & ~d;
            if (slot == 7) m_ctrl = m_ctrl | d;
        end
    endtask

    task automatic model_reset();
        m_sw = '0; m_pos = 0; m_ext = 0; m_phase = '0; m_ctrl = '0; m_dat = '0; m_mreg = '0;
    endtask

    task automatic access(input bit w, input bit r, input int slot, input bit [7:0] d, input string tag);
        @(negedge clk);
        bus_addr  = {slot[3:0], 9'($urandom)};   // R1: low bits random
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = d;
        #1;
        check(tag, bus_rdata, model_read(slot, w, r));
        @(posedge clk);
        model_step(slot, w, r, d);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check(tag, {7'd0, ext_mode}, {7'd0, m_ext});
        check(tag, ext_ctrl, m_ctrl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0;
        @(posedge clk); @(posedge clk);
        model_reset();
        #1;
        rst_n = 1'b1;
    endtask

    task automatic arm_mode_reg();   // Q6 on, Q7 on, motor off (R2)
        access(0, 1, 13, 8'h00, "R2");
        access(0, 1, 15, 8'h00, "R2");
        access(0, 1, 8,  8'h00, "R2");
    endtask

    task automatic send_pattern(input string tag);
        access(1, 0, 15, 8'h57, tag);
        access(1, 0, 15, 8'h17, tag);
        access(1, 0, 15, 8'h57, tag);
        access(1, 0, 15, 8'h57, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E));
        model_reset();
        do_reset();

        // R10: reset state
        check("R10", {7'd0, ext_mode}, 8'h00);
        check("R10", ext_ctrl, 8'h00);
        access(0, 1, 12, 8'h00, "R10");

        // R3: motor on routes bytes to data register, no unlock
        access(0, 1, 13, 8'h00, "R3");
        access(0, 1, 15, 8'h00, "R3");
        access(0, 1, 9,  8'h00, "R3");
        send_pattern("R3");
        check("R3", {7'd0, ext_mode}, 8'h00);

        // R3: Q7 cleared by a read blocks storage
        access(0, 1, 8, 8'h00, "R3");
        access(0, 1, 14, 8'h00, "R2");
        access(1, 0, 12, 8'h57, "R3");
        access(1, 0, 12, 8'h17, "R3");
        access(1, 0, 12, 8'h57, "R3");
        access(1, 0, 12, 8'h57, "R3");
        check("R3", {7'd0, ext_mode}, 8'h00);

        // R4/R5: mismatch holds position, then unlock
        do_reset();
        arm_mode_reg();
        access(1, 0, 15, 8'h57, "R4");
        access(1, 0, 15, 8'h99, "R4");
        access(1, 0, 15, 8'h17, "R4");
        access(1, 0, 15, 8'h57, "R4");
        check("R4", {7'd0, ext_mode}, 8'h00);
        access(1, 0, 15, 8'h57, "R5");
        check("R5", {7'd0, ext_mode}, 8'h01);

        // R6/R8
        access(1, 0, 4, 8'h77, "R6");
        access(0, 1, 12, 8'h00, "R6");
        access(0, 1, 15, 8'h00, "R8");
        access(1, 0, 4, 8'h76, "R8");
        access(0, 1, 15, 8'h00, "R8");
        // R7
        access(1, 0, 7, 8'hA5, "R7");
        check("R7", ext_ctrl, 8'hA5);
        access(1, 0, 6, 8'h05, "R7");
        check("R7", ext_ctrl, 8'hA0);
        // R9
        access(1, 0, 0, 8'hFF, "R9");
        access(1, 0, 1, 8'hFF, "R9");
        access(1, 0, 2, 8'hFF, "R9");
        access(1, 0, 3, 8'hFF, "R9");
        access(1, 0, 5, 8'hFF, "R9");
        access(0, 1, 12, 8'h00, "R9");
        for (int s = 0; s < 16; s++) access(0, 1, s, 8'h00, "R9");
        // R12: both strobes -> write
        access(1, 1, 4, 8'h3C, "R12");
        access(0, 1, 12, 8'h00, "R12");
        // R11: pattern again, stays extended
        arm_mode_reg();
        send_pattern("R11");
        check("R11", {7'd0, ext_mode}, 8'h01);
        // R10: reset returns to legacy
        do_reset();
        check("R10", {7'd0, ext_mode}, 8'h00);
        check("R10", ext_ctrl, 8'h00);

        // R1: write to slot 15 itself arms Q7 in the same access (R3)
        access(0, 1, 13, 8'h00, "R3");
        send_pattern("R3");
        check("R3", {7'd0, ext_mode}, 8'h01);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            int slot;
            bit w, r;
            bit [7:0] d;
            if ($urandom % 400 == 0) do_reset();
            slot = $urandom % 16;
            w = 1'($urandom);
            r = 1'($urandom);
            case ($urandom % 4)
                0: d = 8'h57;
                1: d = 8'h17;
                2: d = 8'h77;
                default: d = 8'($urandom);
            endcase
            access(w, r, slot, d, "R1");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule